// File: doc/BRIEF.md
# System Control Register Bank

A bank of 32-bit control and status words on a simple single-cycle bus. The bus has a byte address, a write strobe, a read strobe, write data and registered read data. The bank decodes a 4 KiB window. Only the first 512 words of that window have storage behind them. A few of those words come out of reset with fixed identification and configuration values. Every other stored word resets to zero.

Three status words read back with two fixed bits forced to one. The stored value in those words is left as it is. One command location near the top of the window holds no storage. Writing a command code there produces a single-cycle system reset request or a single-cycle shutdown request for the surrounding power and reset logic.

Any access to the part of the window with no storage is dropped and reported through a one-cycle access error pulse. The pulse lines up with the read data.

Top module: `sysctl_regbank`

## Requirements
- R1: While reset is held and in the first cycle after it, rdData, accErr, sysResetReq and shutdownReq are all 0. After reset, the words at byte offsets 0x104, 0x100, 0x108 and 0x10C hold 0x00000002, 0x05F20121, 0x05F30121 and 0x05F40121. Every other stored word holds zero.
- R2: The word index is addr[11:2]. A write with wrEn=1 and an index below 512 stores wrData into that word. addr[1:0] is ignored for reads and writes.
- R3: A read (rdEn=1, wrEn=0) of a stored word puts its value on rdData in the cycle after the strobe. In every other cycle rdData is 0.
- R4: A read of word index 0x40, 0x42 or 0x43 (byte offsets 0x100, 0x108, 0x10C) returns the stored value ORed with 0x30000000. Word 0x41 is read back without any forced bits.
- R5: An access to a word index of 512 or more raises accErr for exactly the following cycle. A write there changes no stored word. A read there returns 0.
- R6: A write of 1 or 2 to byte offset 0xF00 raises sysResetReq for exactly one cycle, the cycle after the write.
- R7: A write of 3 to byte offset 0xF00 raises shutdownReq for exactly one cycle, the cycle after the write. Any other value written there raises neither request. The command is not retained, so a read of 0xF00 returns 0 with accErr.
- R8: accErr stays 0 after idle cycles and after accesses to stored words.
- R9: When wrEn and rdEn are both 1, only the write is performed and rdData is 0 in the next cycle.
- R10: sysResetReq and shutdownReq are never 1 in the same cycle. If both were decoded together, the reset request would win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address within the window |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| accErr | output | 1 | Out-of-range access pulse |
| sysResetReq | output | 1 | System reset request pulse |
| shutdownReq | output | 1 | Shutdown request pulse |

## Verification
All four results appear exactly one clock edge after the strobe that causes them: read data, the access error pulse and the two request pulses. A write is visible to a read issued in the very next cycle. The driver predicts all four values for each bus cycle it issues and queues them. The monitor removes one entry 1 ns after each following rising edge, so each expectation is compared in the single cycle it is due. Every idle cycle is also checked against zeros.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W = ADDR_W - 2;
  localparam int DEPTH = 512;
  localparam int MEM_AW = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] CMD_IDX = IDX_W'(12'hF00 >> 2);
  localparam logic [DATA_W-1:0] FORCE_MASK = 32'h3000_0000;
  localparam int N_FORCE = 3;
  localparam logic [IDX_W-1:0] FORCE_IDX [N_FORCE] = '{10'h040, 10'h042, 10'h043};

  typedef struct packed {
    logic wrStore;
    logic rdStore;
    logic rdForce;
    logic cmdReset;
    logic cmdShut;
    logic errHit;
    logic [IDX_W-1:0] idx;
  } ctlStrobes_t;

  function automatic logic [DATA_W-1:0] resetWord(input int i);
    case (i)
      'h40: resetWord = 32'h05F2_0121;
      'h41: resetWord = 32'h0000_0002;
      'h42: resetWord = 32'h05F3_0121;
      'h43: resetWord = 32'h05F4_0121;
      default: resetWord = '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output ctlStrobes_t       strobes,
  output logic              accErr,
  output logic              sysResetReq,
  output logic              shutdownReq
);
  logic [IDX_W-1:0] idx;
  logic inRange;
  logic [N_FORCE-1:0] forceHit;

  assign idx = addr[ADDR_W-1:2];
  assign inRange = int'(idx) < DEPTH;

  for (genvar g = 0; g < N_FORCE; g++) begin : g_force
    assign forceHit[g] = (idx == FORCE_IDX[g]);
  end

  always_comb begin
    strobes.idx = idx;
    strobes.wrStore = wrEn && inRange;
    strobes.rdStore = rdEn && !wrEn && inRange;
    strobes.rdForce = |forceHit;
    strobes.errHit = (wrEn || rdEn) && !inRange;
    strobes.cmdReset = wrEn && (idx == CMD_IDX) &&
                       ((wrData == DATA_W'(1)) || (wrData == DATA_W'(2)));
    strobes.cmdShut = wrEn && (idx == CMD_IDX) && (wrData == DATA_W'(3));
  end

  // reset request wins if both are ever decoded together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accErr <= 1'b0;
      sysResetReq <= 1'b0;
      shutdownReq <= 1'b0;
    end else begin
      accErr <= strobes.errHit;
      sysResetReq <= strobes.cmdReset;
      shutdownReq <= strobes.cmdShut && !strobes.cmdReset;
    end
  end
endmodule

// File: rtl/sysctl_data.sv
module sysctl_data
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [MEM_AW-1:0] wordSel;

  assign wordSel = strobes.idx[MEM_AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= resetWord(i);
      rdData <= '0;
    end else begin
      if (strobes.wrStore) mem[wordSel] <= wrData;
      if (strobes.rdStore)
        rdData <= mem[wordSel] | (strobes.rdForce ? FORCE_MASK : '0);
      else
        rdData <= '0;
    end
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              accErr,
  output logic              sysResetReq,
  output logic              shutdownReq
);
  ctlStrobes_t strobes;

  sysctl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .strobes(strobes), .accErr(accErr),
    .sysResetReq(sysResetReq), .shutdownReq(shutdownReq)
  );

  sysctl_data u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
  import sysctl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              accErr,
  input logic              sysResetReq,
  input logic              shutdownReq
);
  logic oob;
  assign oob = int'(addr[ADDR_W-1:2]) >= DEPTH;

  // R3
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && !wrEn && !oob) |=> rdData == '0);

  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn || rdEn) && oob |=> accErr);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !((wrEn || rdEn) && oob) |=> !accErr);

  // R6
  rst_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr[ADDR_W-1:2] == CMD_IDX && (wrData == 32'd1 || wrData == 32'd2)
    |=> sysResetReq && !shutdownReq);

  // R7
  shut_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr[ADDR_W-1:2] == CMD_IDX && wrData == 32'd3 |=> shutdownReq);

  // R7
  no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !sysResetReq && !shutdownReq);

  // R10
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sysResetReq && shutdownReq));

  // R4
  force_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !wrEn && addr[ADDR_W-1:2] == 10'h042 |=> rdData[29:28] == 2'b11);
endmodule

bind sysctl_regbank sysctl_regbank_chk u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .accErr(accErr),
  .sysResetReq(sysResetReq), .shutdownReq(shutdownReq)
);

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;
  logic clk = 1'b0;
  logic rstN;
  logic [11:0] addr;
  logic wrEn, rdEn;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic accErr, sysResetReq, shutdownReq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] model [512];
  logic [31:0] qData [$];
  logic qErr [$];
  logic qRst [$];
  logic qShut [$];
  string qTag [$];

  always #2 clk = ~clk;

  sysctl_regbank u_sysctl_regbank (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .accErr(accErr),
    .sysResetReq(sysResetReq), .shutdownReq(shutdownReq)
  );

  function automatic bit isForced(input int i);
    return i == 'h40 || i == 'h42 || i == 'h43;
  endfunction

  task automatic step(input logic w, input logic r, input logic [11:0] a,
                      input logic [31:0] d, input string tag);
    int i;
    logic [31:0] eD;
    logic eE, eR, eS;
    @(negedge clk);
    wrEn = w; rdEn = r; addr = a; wrData = d;
    i = int'(a[11:2]);
    eD = '0; eE = 1'b0; eR = 1'b0; eS = 1'b0;
    if (w || r) eE = (i >= 512);
    if (w) begin
      if (i < 512) model[i] = d;
      if (i == 'h3C0) begin
        eR = (d == 1 || d == 2);
        eS = (d == 3);
      end
    end else if (r && i < 512) begin
      eD = model[i] | (isForced(i) ? 32'h3000_0000 : 32'h0);
    end
    qData.push_back(eD); qErr.push_back(eE); qRst.push_back(eR);
    qShut.push_back(eS); qTag.push_back(tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, a, d, tag);
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    step(1'b0, 1'b1, a, '0, tag);
  endtask
  task automatic idle(input string tag);
    step(1'b0, 1'b0, '0, '0, tag);
  endtask

  // monitor: pops one expectation per edge, 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (qData.size() > 0) begin
        logic [31:0] eD;
        logic eE, eR, eS;
        string t;
        eD = qData.pop_front(); eE = qErr.pop_front();
        eR = qRst.pop_front(); eS = qShut.pop_front(); t = qTag.pop_front();
        total++;
        if (rdData !== eD || accErr !== eE || sysResetReq !== eR || shutdownReq !== eS) begin
          bad++;
          $display("FAIL %s: got data=%h err=%b rst=%b shut=%b exp data=%h err=%b rst=%b shut=%b",
                   t, rdData, accErr, sysResetReq, shutdownReq, eD, eE, eR, eS);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) model[i] = '0;
    model['h40] = 32'h05F2_0121;
    model['h41] = 32'h0000_0002;
    model['h42] = 32'h05F3_0121;
    model['h43] = 32'h05F4_0121;
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    total++;
    if (rdData !== '0 || accErr !== 1'b0 || sysResetReq !== 1'b0 || shutdownReq !== 1'b0) begin
      bad++;
      $display("FAIL R1 outputs in reset: got %h %b %b %b exp 0 0 0 0",
               rdData, accErr, sysResetReq, shutdownReq);
    end
    rstN = 1'b1;
    idle("R1 first cycle after reset");
    rd(12'h104, "R1 reset word 0x41");
    rd(12'h100, "R1 R4 reset word 0x40 forced");
    rd(12'h108, "R1 R4 reset word 0x42 forced");
    rd(12'h10C, "R1 R4 reset word 0x43 forced");
    rd(12'h110, "R1 other word zero");
    rd(12'h7FC, "R1 last word zero");
    idle("R3 idle after reads");
    wr(12'h100, 32'h0000_0055, "R2 write forced word");
    rd(12'h100, "R4 forced on written word");
    wr(12'h104, 32'hFFFF_0000, "R2 write word 0x41");
    rd(12'h104, "R4 word 0x41 not forced");
    wr(12'h108, 32'h0, "R2 clear word 0x42");
    rd(12'h108, "R4 forced on zero word");
    wr(12'h000, 32'hA5A5_5A5A, "R2 write word 0");
    wr(12'h7FC, 32'hDEAD_BEEF, "R2 write last word");
    rd(12'h7FC, "R2 read last word");
    rd(12'h000, "R2 read word 0");
    wr(12'h800, 32'h1111_2222, "R5 write first unbacked");
    rd(12'h800, "R5 read first unbacked");
    rd(12'h000, "R5 alias untouched");
    rd(12'hFFC, "R5 read top unbacked");
    wr(12'h203, 32'h0BAD_F00D, "R2 low bits ignored write");
    rd(12'h200, "R2 low bits ignored read");
    rd(12'h202, "R2 low bits ignored read alt");
    wr(12'hF00, 32'd1, "R6 cmd 1");
    idle("R6 pulse ends");
    wr(12'hF00, 32'd2, "R6 cmd 2");
    wr(12'hF00, 32'd3, "R7 R10 cmd 3 back to back");
    idle("R7 pulse ends");
    wr(12'hF00, 32'd0, "R7 cmd 0 no request");
    wr(12'hF00, 32'd4, "R7 cmd 4 no request");
    wr(12'hF00, 32'h0000_0101, "R7 cmd large no request");
    rd(12'hF00, "R7 command not retained");
    wr(12'hF01, 32'd3, "R7 cmd low bits ignored");
    step(1'b1, 1'b1, 12'h010, 32'h1357_9BDF, "R9 write and read together");
    rd(12'h010, "R9 write took effect");
    for (int k = 0; k < 8; k++) begin
      wr(12'(k * 4 + 'h300), 32'h0101_0101 * (k + 1), "R2 pattern write");
    end
    for (int k = 7; k >= 0; k--) begin
      rd(12'(k * 4 + 'h300), "R2 R8 pattern read");
    end
    idle("R8 trailing idle");
    idle("R8 trailing idle");
    while (qData.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule